// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit up/down counter that produces symmetric, phase-correct PWM on two compare channels. The counter climbs from zero to a selectable TOP, stays at TOP for one tick, and descends back to zero. It then stays at zero for one tick and climbs again. TOP can be one of three fixed widths (8, 9 or 10 bits), the value in a capture register, or the active value of compare channel A. The counter only moves on clock cycles where the timer tick enable is high, so an external prescaler sets the rate.

Software reaches the block through a single write port. A compare write goes into a buffer. The buffer is copied into the active compare value on the TOP tick, so every PWM period starts and ends at TOP and stays symmetric when duty or period changes while the timer runs. Each channel can be disconnected, non-inverted or inverted. Sticky flags mark the BOTTOM turnaround, each compare match, and the TOP reload in the two programmable-TOP modes. Software clears a flag by writing a one to it.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset the counter is 0 and counts upward. The control, capture, buffer and active compare registers are 0. All flags and pins are low.
- R2: The counter changes only on cycles with `tick` high in a running mode. It steps by one toward TOP. On the tick where it sits at or above TOP it turns down. On the tick where it sits at 0 while descending it turns up to 1. It therefore shows TOP and 0 each for one tick per turn.
- R3: Control bits [3:0] select the wave mode. Mode 1 gives TOP = 0x00FF, mode 2 gives 0x01FF, mode 3 gives 0x03FF, mode 10 takes TOP from the capture register, and mode 11 takes TOP from channel A's active compare value. Every other mode holds the counter and raises no events.
- R4: The overflow flag (clear bit 0) is set on the cycle after the tick on which the counter sits at 0 while descending.
- R5: A compare write updates only the buffer. The active value takes the buffer contents on the TOP tick. A write and a reload in the same cycle give the old buffer to the active value and the new data to the buffer.
- R6: On the TOP tick, mode 10 sets the capture-TOP flag (clear bit 3) and mode 11 sets the compare-A flag (clear bit 1).
- R7: In modes 1 to 3 a compare write is ANDed with the current TOP, which clears the bits above the active resolution. In other modes it is stored unmasked.
- R8: A channel's compare flag (A = clear bit 1, B = clear bit 2) is set after each running tick on which the counter equals that channel's active value. A channel whose active value is above TOP never matches.
- R9: Control bits [5:4] select the output mode of channel A and bits [7:6] that of channel B. Modes 0 and 1 drive the pin low. In mode 2 a match on the rising slope clears the waveform and a match on the falling slope sets it; the BOTTOM tick belongs to the rising slope and the TOP tick to the falling slope. Mode 3 drives the complement of the mode 2 waveform.
- R10: Flags stay set until software writes a one to their bit at address 4. A set event and a clear of the same flag in the same cycle leave the flag set.
- R11: The write addresses are: 0 for control, 1 for channel A's buffer, 2 for channel B's buffer, 3 for the capture register and 4 for the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_out | output | 16 | Current counter value |
| pwm_out | output | 2 | PWM pins, bit 0 = channel A |
| flag_ovf | output | 1 | BOTTOM (overflow) flag |
| flag_cmp | output | 2 | Compare-match flags, bit 0 = channel A |
| flag_top_cap | output | 1 | Capture-as-TOP flag |

## Verification
Two collisions are provoked on purpose. In the first, a compare-buffer write lands on the TOP reload tick. This must split cleanly: the old buffer goes to the active value and the new data stays in the buffer. In the second, a software flag clear lands on the BOTTOM tick that sets the overflow flag, and the flag must stay set. The bench steps its own cycle model until the model predicts the turnaround is the next tick, then issues the write on exactly that cycle. Randomly timed writes also hit these and the compare-flag collisions by chance. Every pin, flag and counter value is compared against the model on every cycle.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  localparam logic [3:0] WM_FIX8     = 4'd1;
  localparam logic [3:0] WM_FIX9     = 4'd2;
  localparam logic [3:0] WM_FIX10    = 4'd3;
  localparam logic [3:0] WM_TOP_CAP  = 4'd10;
  localparam logic [3:0] WM_TOP_CMPA = 4'd11;

  localparam logic [1:0] OM_NONINV = 2'd2;
  localparam logic [1:0] OM_INV    = 2'd3;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CMP0 = 1;
  localparam int WMODE_W   = 4;
  localparam int OMODE_W   = 2;
endpackage

// File: rtl/pcpwm_regs.sv
module pcpwm_regs
  import pcpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                  wr_data,
  input  logic                              set_ovf,
  input  logic [NUM_CH-1:0]                 set_cmp,
  input  logic                              set_cap,
  output logic [WMODE_W-1:0]                wave_mode,
  output logic [NUM_CH-1:0][OMODE_W-1:0]    out_mode,
  output logic [CNT_W-1:0]                  cap_val,
  output logic                              flg_ovf,
  output logic [NUM_CH-1:0]                 flg_cmp,
  output logic                              flg_cap
);
  localparam int CTRL_W   = WMODE_W + OMODE_W * NUM_CH;
  localparam int CAP_ADDR = ADDR_CMP0 + NUM_CH;
  localparam int FLG_ADDR = CAP_ADDR + 1;
  localparam int FLG_W    = NUM_CH + 2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cap_q, cap_d;
  logic [FLG_W-1:0]  flg_q, flg_d, flg_set, flg_clr;

  always_comb begin
    ctrl_d  = ctrl_q;
    cap_d   = cap_q;
    flg_clr = '0;
    if (wr_en && (wr_addr == ADDR_W'(ADDR_CTRL))) ctrl_d = wr_data[CTRL_W-1:0];
    if (wr_en && (wr_addr == ADDR_W'(CAP_ADDR)))  cap_d  = wr_data;
    if (wr_en && (wr_addr == ADDR_W'(FLG_ADDR)))  flg_clr = wr_data[FLG_W-1:0];
    flg_set = {set_cap, set_cmp, set_ovf};
    // a set event in the same cycle as a clear wins
    flg_d   = (flg_q & ~flg_clr) | flg_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cap_q  <= '0;
      flg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cap_q  <= cap_d;
      flg_q  <= flg_d;
    end
  end

  assign wave_mode = ctrl_q[WMODE_W-1:0];
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_om
      assign out_mode[i] = ctrl_q[WMODE_W + OMODE_W*i +: OMODE_W];
    end
  endgenerate
  assign cap_val = cap_q;
  assign flg_ovf = flg_q[0];
  assign flg_cmp = flg_q[NUM_CH:1];
  assign flg_cap = flg_q[NUM_CH+1];
endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [WMODE_W-1:0] wave_mode,
  input  logic [CNT_W-1:0]   cap_val,
  input  logic [CNT_W-1:0]   act_a,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cmp_mask,
  output logic               rising,
  output logic               run_tick,
  output logic               ev_top,
  output logic               ev_bot
);
  localparam logic [CNT_W-1:0] TOP8  = CNT_W'(10'h0FF);
  localparam logic [CNT_W-1:0] TOP9  = CNT_W'(10'h1FF);
  localparam logic [CNT_W-1:0] TOP10 = CNT_W'(10'h3FF);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, top;
  logic             up_q, up_d, run, fixed, at_top, at_bot;

  always_comb begin
    run   = 1'b1;
    fixed = 1'b0;
    top   = '1;
    case (wave_mode)
      WM_FIX8:     begin top = TOP8;  fixed = 1'b1; end
      WM_FIX9:     begin top = TOP9;  fixed = 1'b1; end
      WM_FIX10:    begin top = TOP10; fixed = 1'b1; end
      WM_TOP_CAP:  top = cap_val;
      WM_TOP_CMPA: top = act_a;
      default:     run = 1'b0;
    endcase
  end

  assign cmp_mask = fixed ? top : '1;
  assign at_top   = up_q && (cnt_q >= top);
  assign at_bot   = !up_q && (cnt_q == '0);
  assign rising   = up_q ? !at_top : at_bot;
  assign run_tick = tick && run;
  assign ev_top   = run_tick && at_top;
  assign ev_bot   = run_tick && at_bot;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (run_tick) begin
      if (up_q) begin
        if (at_top) begin
          up_d = 1'b0;
          if (cnt_q != '0) cnt_d = cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (at_bot) begin
          up_d  = 1'b1;
          cnt_d = ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W-1:0]   cmp_mask,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               rising,
  input  logic               run_tick,
  input  logic               ev_top,
  input  logic [OMODE_W-1:0] out_mode,
  output logic [CNT_W-1:0]   buf_val,
  output logic [CNT_W-1:0]   act_val,
  output logic               match,
  output logic               pwm
);
  logic [CNT_W-1:0] buf_q, buf_d, act_q, act_d;
  logic             oc_q, oc_d;

  always_comb begin
    buf_d = wr_stb ? (wr_data & cmp_mask) : buf_q;
    act_d = ev_top ? buf_q : act_q;
    match = run_tick && (cnt == act_q);
    oc_d  = oc_q;
    if (match) oc_d = !rising;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
      oc_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
      oc_q  <= oc_d;
    end
  end

  always_comb begin
    case (out_mode)
      OM_NONINV: pwm = oc_q;
      OM_INV:    pwm = !oc_q;
      default:   pwm = 1'b0;
    endcase
  end

  assign buf_val = buf_q;
  assign act_val = act_q;
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              flag_ovf,
  output logic [NUM_CH-1:0] flag_cmp,
  output logic              flag_top_cap
);
  logic [WMODE_W-1:0]             wave_mode;
  logic [NUM_CH-1:0][OMODE_W-1:0] out_mode;
  logic [CNT_W-1:0]               cap_val, cmp_mask;
  logic [CNT_W-1:0]               ch_act [NUM_CH];
  logic [CNT_W-1:0]               ch_buf [NUM_CH];
  logic [NUM_CH-1:0]              ch_match, set_cmp;
  logic                           rising, run_tick, ev_top, ev_bot;

  pcpwm_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_ovf(ev_bot), .set_cmp(set_cmp),
    .set_cap(ev_top && (wave_mode == WM_TOP_CAP)),
    .wave_mode(wave_mode), .out_mode(out_mode), .cap_val(cap_val),
    .flg_ovf(flag_ovf), .flg_cmp(flag_cmp), .flg_cap(flag_top_cap)
  );

  pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wave_mode(wave_mode), .cap_val(cap_val), .act_a(ch_act[0]),
    .cnt(cnt_out), .cmp_mask(cmp_mask), .rising(rising),
    .run_tick(run_tick), .ev_top(ev_top), .ev_bot(ev_bot)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pcpwm_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + i))),
        .wr_data(wr_data), .cmp_mask(cmp_mask), .cnt(cnt_out),
        .rising(rising), .run_tick(run_tick), .ev_top(ev_top),
        .out_mode(out_mode[i]),
        .buf_val(ch_buf[i]), .act_val(ch_act[i]),
        .match(ch_match[i]), .pwm(pwm_out[i])
      );
      if (i == 0) begin : g_top_flag
        // channel A's flag also marks the TOP reload when it defines TOP
        assign set_cmp[i] = ch_match[i] || (ev_top && (wave_mode == WM_TOP_CMPA));
      end else begin : g_plain_flag
        assign set_cmp[i] = ch_match[i];
      end
    end
  endgenerate
endmodule

// File: rtl/pcpwm_checker.sv
module pcpwm_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run_tick,
  input logic              ev_top,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              clr_bit0,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  buf_a,
  input logic [CNT_W-1:0]  act_a,
  input logic              flag_ovf
);
  localparam int FLG_ADDR = NUM_CH + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ovf_clr;
  assign ovf_clr = wr_en && (wr_addr == ADDR_W'(FLG_ADDR)) && clr_bit0;

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_tick |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE) ||
                  ((cnt == '0) && ($past(cnt) == '0))));

  a_r4_ovf_from_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> ($past(cnt) == '0));

  a_r5_reload_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    ev_top |=> (act_a == $past(buf_a)));

  a_r5_active_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_top |=> $stable(act_a));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !ovf_clr) |=> flag_ovf);
endmodule

bind pcpwm_timer pcpwm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_tick(run_tick), .ev_top(ev_top),
  .wr_en(wr_en), .wr_addr(wr_addr), .clr_bit0(wr_data[0]),
  .cnt(cnt_out), .buf_a(ch_buf[0]), .act_a(ch_act[0]), .flag_ovf(flag_ovf)
);

// File: tb/tb_pcpwm_timer.sv
module tb_pcpwm_timer;
  logic        clk, rst_n, tick, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] cnt_out;
  logic [1:0]  pwm_out, flag_cmp;
  logic        flag_ovf, flag_top_cap;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_cnt, m_cap;
  logic        m_up;
  logic [7:0]  m_ctrl;
  logic [15:0] m_buf [2];
  logic [15:0] m_act [2];
  logic [1:0]  m_oc;
  logic [3:0]  m_flg;

  pcpwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_out(cnt_out), .pwm_out(pwm_out), .flag_ovf(flag_ovf),
    .flag_cmp(flag_cmp), .flag_top_cap(flag_top_cap)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_run(input logic [3:0] md);
    return (md == 4'd1) || (md == 4'd2) || (md == 4'd3) || (md == 4'd10) || (md == 4'd11);
  endfunction

  function automatic logic f_fixed(input logic [3:0] md);
    return (md == 4'd1) || (md == 4'd2) || (md == 4'd3);
  endfunction

  function automatic logic [15:0] f_top(input logic [3:0] md, input logic [15:0] cap,
                                        input logic [15:0] acta);
    case (md)
      4'd1:    return 16'h00FF;
      4'd2:    return 16'h01FF;
      4'd3:    return 16'h03FF;
      4'd10:   return cap;
      4'd11:   return acta;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic f_pin(input logic [1:0] om, input logic oc);
    if (om == 2'd3) return !oc;
    if (om == 2'd2) return oc;
    return 1'b0;
  endfunction

  function automatic logic f_next_is_top();
    return f_run(m_ctrl[3:0]) && m_up && (m_cnt >= f_top(m_ctrl[3:0], m_cap, m_act[0]));
  endfunction

  function automatic logic f_next_is_bot();
    return f_run(m_ctrl[3:0]) && !m_up && (m_cnt == 16'd0);
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_up = 1'b1; m_ctrl = '0; m_cap = '0;
    m_oc = '0; m_flg = '0;
    for (int c = 0; c < 2; c++) begin m_buf[c] = '0; m_act[c] = '0; end
  endtask

  task automatic model_step(input logic t, input logic w, input logic [2:0] a, input logic [15:0] d);
    logic [3:0]  md;
    logic [15:0] top, n_cnt;
    logic        rt, at_top, at_bot, rising, n_up;
    logic [15:0] n_buf [2];
    logic [15:0] n_act [2];
    logic [1:0]  n_oc, match;
    logic [3:0]  setv, clrv;
    md     = m_ctrl[3:0];
    top    = f_top(md, m_cap, m_act[0]);
    rt     = t && f_run(md);
    at_top = m_up && (m_cnt >= top);
    at_bot = !m_up && (m_cnt == 16'd0);
    rising = m_up ? !at_top : at_bot;
    for (int c = 0; c < 2; c++) begin
      match[c] = rt && (m_cnt == m_act[c]);
      n_oc[c]  = match[c] ? !rising : m_oc[c];
      n_act[c] = (rt && at_top) ? m_buf[c] : m_act[c];
      n_buf[c] = (w && a == 3'(1 + c)) ? (d & (f_fixed(md) ? top : 16'hFFFF)) : m_buf[c];
    end
    n_cnt = m_cnt; n_up = m_up;
    if (rt) begin
      if (m_up) begin
        if (at_top) begin n_up = 1'b0; if (m_cnt != 0) n_cnt = m_cnt - 16'd1; end
        else n_cnt = m_cnt + 16'd1;
      end else begin
        if (at_bot) begin n_up = 1'b1; n_cnt = 16'd1; end
        else n_cnt = m_cnt - 16'd1;
      end
    end
    setv[0] = rt && at_bot;
    setv[1] = match[0] || (rt && at_top && md == 4'd11);
    setv[2] = match[1];
    setv[3] = rt && at_top && md == 4'd10;
    clrv    = (w && a == 3'd4) ? d[3:0] : 4'd0;
    m_flg   = (m_flg & ~clrv) | setv;
    if (w && a == 3'd0) m_ctrl = d[7:0];
    if (w && a == 3'd3) m_cap = d;
    m_cnt = n_cnt; m_up = n_up; m_oc = n_oc;
    for (int c = 0; c < 2; c++) begin m_buf[c] = n_buf[c]; m_act[c] = n_act[c]; end
  endtask

  task automatic check_all();
    logic [1:0] ep;
    ep[0] = f_pin(m_ctrl[5:4], m_oc[0]);
    ep[1] = f_pin(m_ctrl[7:6], m_oc[1]);
    chk(cnt_out == m_cnt, "R2 R3 R11 counter", cnt_out, m_cnt);
    chk(flag_ovf == m_flg[0], "R4 R10 overflow flag", flag_ovf, m_flg[0]);
    chk(flag_cmp == m_flg[2:1], "R8 R6 compare flags", flag_cmp, m_flg[2:1]);
    chk(flag_top_cap == m_flg[3], "R6 capture-TOP flag", flag_top_cap, m_flg[3]);
    chk(pwm_out == ep, "R9 R5 R7 pins", pwm_out, ep);
  endtask

  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [15:0] d);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    model_step(t, w, a, d);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 16'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7031));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R1: reset state
    chk(cnt_out == 16'd0, "R1 counter at reset", cnt_out, 0);
    chk({flag_ovf, flag_cmp, flag_top_cap} == 4'd0, "R1 flags at reset",
        {flag_ovf, flag_cmp, flag_top_cap}, 0);
    chk(pwm_out == 2'd0, "R1 pins at reset", pwm_out, 0);
    // R3: mode 0 holds the counter
    run(5);
    chk(cnt_out == 16'd0, "R3 idle mode holds counter", cnt_out, 0);

    // R7: 8-bit mode masks 0x1234 to 0x34; A non-inverted, B inverted
    wr(3'd0, 16'h00E1);
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'h0080);
    run(1200);
    // R2: tick gating
    for (int i = 0; i < 300; i++) cyc(1'($urandom_range(0, 1)), 1'b0, 3'd0, 16'd0);

    // R6 R8: capture TOP = 3 (2-bit); B above TOP never matches
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h00EA);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd5);
    run(100);
    chk(flag_cmp[1] == 1'b0 || m_flg[2], "R8 no match above TOP", flag_cmp[1], m_flg[2]);

    // R6: compare A as TOP
    wr(3'd0, 16'h00EB);
    wr(3'd1, 16'd20);
    wr(3'd2, 16'd7);
    run(200);
    wr(3'd1, 16'd40);
    run(200);

    // R5: buffer write on the reload tick
    while (!f_next_is_top()) cyc(1'b1, 1'b0, 3'd0, 16'd0);
    cyc(1'b1, 1'b1, 3'd1, 16'd30);
    run(150);
    // R10: clear on the BOTTOM tick loses to the set
    while (!f_next_is_bot()) cyc(1'b1, 1'b0, 3'd0, 16'd0);
    cyc(1'b1, 1'b1, 3'd4, 16'h000F);
    chk(flag_ovf == 1'b1, "R10 set wins over clear", flag_ovf, 1);
    wr(3'd4, 16'h000F);
    chk(flag_ovf == 1'b0, "R10 write-one clears", flag_ovf, 0);

    // R7 R9: 9- and 10-bit modes, A inverted, B disconnected
    wr(3'd0, 16'h0032);
    wr(3'd1, 16'hFF00);
    run(1100);
    wr(3'd0, 16'h0033);
    wr(3'd1, 16'h0200);
    wr(3'd2, 16'h0100);
    run(2100);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic       t, w;
      logic [2:0] a;
      logic [15:0] d;
      t = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 15) == 0);
      a = 3'($urandom_range(0, 4));
      case (a)
        3'd0: begin
          logic [3:0] md;
          case ($urandom_range(0, 6))
            0: md = 4'd1; 1: md = 4'd2; 2: md = 4'd3; 3: md = 4'd10;
            4: md = 4'd11; 5: md = 4'd0; default: md = 4'd5;
          endcase
          d = {8'd0, 4'($urandom_range(0, 15)), md};
        end
        3'd3:    d = 16'($urandom_range(3, 300));
        3'd4:    d = 16'($urandom_range(0, 15));
        default: d = 16'($urandom_range(0, 300));
      endcase
      cyc(t, w, a, d);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule